// File: doc/BRIEF.md
# Multi-link sync and power shim

This block is the register-mapped control shim for a controller that drives up to four serial audio links. A single register port gives software three words: a read-only capability word, a link-control word that runs a power request/acknowledge handshake per link, and a shared sync word. The sync word carries the period that the link timing logic uses, together with a request bit that loads a new period. It also holds one arm bit per link and a shared go bit. Software arms the links that have to change bank together, then writes the go bit. Every armed link then gets a one-cycle bank-switch strobe on the same clock edge, and all arm bits clear at once.

Three kinds of state machine do the work. The load machine has two states. LD_IDLE moves to LD_WAIT on a sync write with the load bit set, and LD_WAIT returns to LD_IDLE when its down-counter reaches zero, which is also when the period output updates. The go machine has two states. GO_IDLE moves to GO_ISSUE on a sync write with the go bit and at least one arm bit set, and GO_ISSUE always returns to GO_IDLE after one cycle, which fires the strobes. Each link has its own power machine with four states:
- PW_OFF moves to PW_RISING when the request is high.
- PW_RISING goes back to PW_OFF if the request drops, or moves to PW_ON when its counter expires.
- PW_ON moves to PW_FALLING when the request drops.
- PW_FALLING goes back to PW_ON if the request returns, or moves to PW_OFF when its counter expires.

The acknowledge output is high in PW_ON and in PW_FALLING.

Top module: `link_sync_shim`

## Requirements
- R1: After reset, the period output, all strobes, all power requests and all acknowledges are 0, and the link-control and sync words read 0.
- R2: Address 0x0 reads NUM_LINKS in bits 2:0 and 0 elsewhere, and writes to it have no effect. Addresses other than 0x0, 0x4 and 0x8 read 0.
- R3: At address 0x8, bits 14:0 hold the period field and read back the last value written. Writing bit 15 = 1 makes bit 15 read 1 for exactly LOAD_DELAY cycles. The period output takes the field value on the edge where bit 15 clears. A write with bit 15 = 0 leaves the period output unchanged.
- R4: Sync bits 19:16 are the arm bits, with bit 16+n for link n. A sync write without the go bit stores them, they read back, and no strobe fires.
- R5: A sync write with bit 24 = 1 and a non-zero arm field makes bit 24 read 1 for one cycle. On the next edge, every armed link's strobe goes high for exactly one cycle, and the arm bits and bit 24 clear together.
- R6: A sync write with bit 24 = 1 and an arm field of zero fires no strobe, and bit 24 reads 0.
- R7: At address 0x4, bit n is the power request of link n and drives its request output. The acknowledge, readable at bit 8+n, rises on the (PWR_DELAY+1)-th edge after the write that set the request.
- R8: The acknowledge falls on the (PWR_DELAY+1)-th edge after the write that clears the request. Writing bits 8+n has no effect on the acknowledges.
- R9: If a request is withdrawn before its acknowledge has risen, the acknowledge stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| sync_period | output | 15 | Period value currently in use |
| bank_strobe | output | NUM_LINKS | One-cycle bank-switch pulse per link |
| link_pwr_req | output | NUM_LINKS | Power request per link |
| link_pwr_ack | output | NUM_LINKS | Power acknowledge per link |

## Verification
The embedded assertions check the following on every cycle:
- A strobe only follows a go cycle, and the arm field is empty whenever a strobe fires.
- The go bit never stays set for two cycles.
- The period output changes only when a load completes, and then to the field value.
- An acknowledge edge always follows a request of the same polarity.

The exact counts of the load and power delays, the exact set of strobed links for every arm pattern, the read-only acknowledge bits and the aborted power-up can only be shown by the bench's directed sweeps.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

    localparam int REG_ADDR_W = 4;

    localparam logic [REG_ADDR_W-1:0] ADDR_CAP  = 4'h0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTL  = 4'h4;
    localparam logic [REG_ADDR_W-1:0] ADDR_SYNC = 4'h8;

    localparam int PERIOD_W    = 15;
    localparam int LOAD_BIT    = 15;
    localparam int ARM_LSB     = 16;
    localparam int GO_BIT      = 24;
    localparam int ACK_LSB     = 8;
    localparam int MAX_LINKS   = 4;

    typedef enum logic [1:0] {
        PW_OFF,
        PW_RISING,
        PW_ON,
        PW_FALLING
    } pwr_state_e;

    typedef enum logic {
        LD_IDLE,
        LD_WAIT
    } load_state_e;

    typedef enum logic {
        GO_IDLE,
        GO_ISSUE
    } go_state_e;

endpackage

// File: rtl/link_pwr_fsm.sv
module link_pwr_fsm
    import link_sync_pkg::*;
#(
    parameter int PWR_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    output logic pwr_ack
);
    localparam int CNT_W = (PWR_DELAY < 2) ? 1 : $clog2(PWR_DELAY);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PWR_DELAY - 1);

    pwr_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            PW_OFF:     if (pwr_req) state_nx = PW_RISING;
            PW_RISING:  if (!pwr_req) state_nx = PW_OFF;
                        else if (cnt == '0) state_nx = PW_ON;
            PW_ON:      if (!pwr_req) state_nx = PW_FALLING;
            PW_FALLING: if (pwr_req) state_nx = PW_ON;
                        else if (cnt == '0) state_nx = PW_OFF;
            default:    state_nx = PW_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if ((state_nx == PW_RISING && state != PW_RISING) ||
                (state_nx == PW_FALLING && state != PW_FALLING))
                cnt <= CNT_LOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        pwr_ack = (state == PW_ON) || (state == PW_FALLING);
    end

    assert_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ack) |-> $past(pwr_req));

    assert_ack_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_ack) |-> !$past(pwr_req));

endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
    import link_sync_pkg::*;
#(
    parameter int NUM_LINKS  = 4,
    parameter int LOAD_DELAY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sync,
    input  logic [PERIOD_W-1:0]  wr_period,
    input  logic                 wr_load,
    input  logic [NUM_LINKS-1:0] wr_arm,
    input  logic                 wr_go,
    output logic [PERIOD_W-1:0]  period_field,
    output logic                 ld_busy,
    output logic [NUM_LINKS-1:0] arm,
    output logic                 go_busy,
    output logic [PERIOD_W-1:0]  sync_period,
    output logic [NUM_LINKS-1:0] bank_strobe
);
    localparam int LD_CW = (LOAD_DELAY < 2) ? 1 : $clog2(LOAD_DELAY);
    localparam logic [LD_CW-1:0] LD_LOAD = LD_CW'(LOAD_DELAY - 1);

    load_state_e ld_state, ld_nx;
    go_state_e   go_state, go_nx;
    logic [LD_CW-1:0] ld_cnt;

    // period load machine
    always_comb begin
        ld_nx = ld_state;
        unique case (ld_state)
            LD_IDLE: if (wr_sync && wr_load) ld_nx = LD_WAIT;
            LD_WAIT: if (ld_cnt == '0) ld_nx = LD_IDLE;
            default: ld_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_state     <= LD_IDLE;
            ld_cnt       <= '0;
            period_field <= '0;
            sync_period  <= '0;
        end else begin
            ld_state <= ld_nx;
            if (ld_state == LD_IDLE && ld_nx == LD_WAIT)
                ld_cnt <= LD_LOAD;
            else if (ld_cnt != '0)
                ld_cnt <= ld_cnt - 1'b1;
            if (wr_sync)
                period_field <= wr_period;
            if (ld_state == LD_WAIT && ld_nx == LD_IDLE)
                sync_period <= period_field;
        end
    end

    // bank-switch go machine
    always_comb begin
        go_nx = go_state;
        unique case (go_state)
            GO_IDLE:  if (wr_sync && wr_go && (wr_arm != '0)) go_nx = GO_ISSUE;
            GO_ISSUE: go_nx = GO_IDLE;
            default:  go_nx = GO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_state    <= GO_IDLE;
            arm         <= '0;
            bank_strobe <= '0;
        end else begin
            go_state <= go_nx;
            if (go_state == GO_ISSUE) begin
                bank_strobe <= arm;
                arm         <= '0;
            end else begin
                bank_strobe <= '0;
                if (wr_sync)
                    arm <= wr_arm;
            end
        end
    end

    always_comb begin
        ld_busy = (ld_state == LD_WAIT);
        go_busy = (go_state == GO_ISSUE);
    end

    assert_strobe_after_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_strobe != '0) |-> $past(go_busy));

    assert_arm_clear_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_strobe != '0) |-> (arm == '0));

    assert_go_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_busy |=> !go_busy);

    assert_period_takes_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_busy) |-> (sync_period == $past(period_field)));

    assert_period_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ld_busy) |-> $stable(sync_period));

endmodule

// File: rtl/link_sync_shim.sv
module link_sync_shim
    import link_sync_pkg::*;
#(
    parameter int NUM_LINKS  = 4,
    parameter int PWR_DELAY  = 4,
    parameter int LOAD_DELAY = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [14:0]           sync_period,
    output logic [NUM_LINKS-1:0]  bank_strobe,
    output logic [NUM_LINKS-1:0]  link_pwr_req,
    output logic [NUM_LINKS-1:0]  link_pwr_ack
);
    localparam logic [31:0] LINK_MASK = 32'((64'd1 << NUM_LINKS) - 1);
    localparam logic [31:0] USED_MASK = LINK_MASK | (LINK_MASK << ARM_LSB) |
                                        32'h0000_FFFF | (32'd1 << GO_BIT);

    logic wr_ctl, wr_sync;
    logic [PERIOD_W-1:0]  period_field;
    logic                 ld_busy, go_busy;
    logic [NUM_LINKS-1:0] arm;
    logic                 unused_wbits;

    initial begin
        if (NUM_LINKS < 1 || NUM_LINKS > MAX_LINKS)
            $error("NUM_LINKS out of range");
    end

    assign wr_ctl       = reg_wr && (reg_addr == ADDR_CTL);
    assign wr_sync      = reg_wr && (reg_addr == ADDR_SYNC);
    assign unused_wbits = ^(reg_wdata & ~USED_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            link_pwr_req <= '0;
        else if (wr_ctl)
            link_pwr_req <= reg_wdata[NUM_LINKS-1:0];
    end

    for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link
        link_pwr_fsm #(.PWR_DELAY(PWR_DELAY)) u_pwr (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_req (link_pwr_req[n]),
            .pwr_ack (link_pwr_ack[n])
        );
    end

    sync_ctrl #(.NUM_LINKS(NUM_LINKS), .LOAD_DELAY(LOAD_DELAY)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_sync      (wr_sync),
        .wr_period    (reg_wdata[PERIOD_W-1:0]),
        .wr_load      (reg_wdata[LOAD_BIT]),
        .wr_arm       (reg_wdata[ARM_LSB +: NUM_LINKS]),
        .wr_go        (reg_wdata[GO_BIT]),
        .period_field (period_field),
        .ld_busy      (ld_busy),
        .arm          (arm),
        .go_busy      (go_busy),
        .sync_period  (sync_period),
        .bank_strobe  (bank_strobe)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CAP:  reg_rdata[2:0] = 3'(NUM_LINKS);
            ADDR_CTL: begin
                reg_rdata[NUM_LINKS-1:0]          = link_pwr_req;
                reg_rdata[ACK_LSB +: NUM_LINKS]   = link_pwr_ack;
            end
            ADDR_SYNC: begin
                reg_rdata[PERIOD_W-1:0]           = period_field;
                reg_rdata[LOAD_BIT]               = ld_busy;
                reg_rdata[ARM_LSB +: NUM_LINKS]   = arm;
                reg_rdata[GO_BIT]                 = go_busy;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_strobe_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_strobe & ~$past(arm)) == '0);

endmodule

// File: tb/link_sync_shim_test.sv
module link_sync_shim_test;
    localparam int N  = 4;
    localparam int PD = 4;
    localparam int LD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [14:0] sync_period;
    logic [N-1:0] bank_strobe, link_pwr_req, link_pwr_ack;

    int n_run = 0;
    int n_fail = 0;
    logic [14:0] exp_field = '0;
    logic [14:0] exp_period = '0;

    always #2 clk = ~clk;

    link_sync_shim #(.NUM_LINKS(N), .PWR_DELAY(PD), .LOAD_DELAY(LD)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_period(sync_period),
        .bank_strobe(bank_strobe), .link_pwr_req(link_pwr_req),
        .link_pwr_ack(link_pwr_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(4'h4, d); check("R1 ctl", d, 0);
        rd(4'h8, d); check("R1 sync", d, 0);
        check("R1 period", 32'(sync_period), 0);
        check("R1 strobe", 32'(bank_strobe), 0);
        check("R1 req/ack", 32'({link_pwr_req, link_pwr_ack}), 0);

        // R2 capability and unmapped addresses
        rd(4'h0, d); check("R2 cap", d, N);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R2 cap write ignored", d, N);
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4 && a != 8) begin
                rd(4'(a), d); check("R2 unmapped", d, 0);
            end
        end

        // R3 period field without load
        wr(4'h8, 32'h0000_1234); exp_field = 15'h1234;
        rd(4'h8, d); check("R3 field readback", d, 32'h1234);
        step();
        check("R3 no load keeps output", 32'(sync_period), 32'(exp_period));

        // R3 period load sequences
        for (int v = 0; v < 2; v++) begin
            logic [14:0] val;
            val = (v == 0) ? 15'h176F : 15'h0055;
            wr(4'h8, 32'h8000 | 32'(val)); exp_field = val;
            rd(4'h8, d); check("R3 load busy", d, 32'h8000 | 32'(val));
            check("R3 old period during load", 32'(sync_period), 32'(exp_period));
            for (int k = 1; k < LD; k++) begin
                step();
                rd(4'h8, d); check("R3 load still busy", 32'(d[15]), 1);
                check("R3 period waits", 32'(sync_period), 32'(exp_period));
            end
            step();
            exp_period = val;
            rd(4'h8, d); check("R3 load done", d, 32'(val));
            check("R3 period updated", 32'(sync_period), 32'(exp_period));
        end

        // R4, R5, R6 sweep over all arm patterns
        for (int m = 0; m < 16; m++) begin
            logic [31:0] base;
            base = 32'(exp_field) | (32'(m) << 16);
            wr(4'h8, base);
            rd(4'h8, d); check("R4 arm readback", d, base);
            check("R4 no strobe on arm", 32'(bank_strobe), 0);
            wr(4'h8, base | 32'h0100_0000);
            rd(4'h8, d);
            if (m != 0) begin
                check("R5 go reads busy", d, base | 32'h0100_0000);
                check("R5 no strobe yet", 32'(bank_strobe), 0);
                step();
                check("R5 strobe equals arm", 32'(bank_strobe), m);
                rd(4'h8, d); check("R5 arm and go cleared", d, 32'(exp_field));
                step();
                check("R5 strobe one cycle", 32'(bank_strobe), 0);
            end else begin
                check("R6 go without arm reads 0", d, 32'(exp_field));
                step();
                check("R6 no strobe", 32'(bank_strobe), 0);
            end
        end
        // R6 go written with empty arm field after arming
        wr(4'h8, 32'(exp_field) | 32'h0005_0000);
        wr(4'h8, 32'(exp_field) | 32'h0100_0000);
        rd(4'h8, d); check("R6 empty arm go", d, 32'(exp_field));
        step(); check("R6 empty arm no strobe", 32'(bank_strobe), 0);

        // R7, R8 per-link power handshake
        for (int n = 0; n < N; n++) begin
            logic [31:0] rq;
            rq = 32'd1 << n;
            wr(4'h4, rq);
            check("R7 req output", 32'(link_pwr_req), rq);
            for (int k = 1; k <= PD; k++) begin
                check("R7 ack waits", 32'(link_pwr_ack), 0);
                step();
            end
            step();
            check("R7 ack rises", 32'(link_pwr_ack), rq);
            rd(4'h4, d); check("R7 ack readback", d, rq | (rq << 8));
            wr(4'h4, rq | 32'h0000_0F00);
            step();
            rd(4'h4, d); check("R8 ack bits read-only", d, rq | (rq << 8));
            wr(4'h4, 0);
            for (int k = 1; k <= PD; k++) begin
                check("R8 ack holds", 32'(link_pwr_ack), rq);
                step();
            end
            step();
            check("R8 ack falls", 32'(link_pwr_ack), 0);
        end
        wr(4'h4, 32'h0000_0F00);
        repeat (PD + 2) step();
        rd(4'h4, d); check("R8 write to ack while off", d, 0);

        // R7 all links together
        wr(4'h4, 32'hF);
        repeat (PD + 1) step();
        check("R7 all acks", 32'(link_pwr_ack), 32'hF);
        wr(4'h4, 0);
        repeat (PD + 1) step();
        check("R8 all acks fall", 32'(link_pwr_ack), 0);

        // R9 aborted power-up
        wr(4'h4, 32'h4);
        step();
        wr(4'h4, 0);
        for (int k = 0; k < 3 * PD; k++) begin
            check("R9 ack stays low", 32'(link_pwr_ack), 0);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule